// File: doc/BRIEF.md
# Graphics DRAM Power-Up Sequencer

This block sits on the controller side of a graphics DRAM channel and drives the device through its required power-up steps. After a start pulse, it keeps the device reset pin low and the command bus deselected for a programmable wait. It then releases reset while presenting a termination-strength strap on CKE, and drives CKE high. After a second wait, it issues a fixed chain of commands: precharge-all, extended mode register load, mode register load with the DLL reset bit, a second precharge-all, and two auto refreshes. When the last refresh has recovered and the DLL lock interval has elapsed, it raises a done flag.

Each microsecond-scale wait lasts `waitCycles` clocks, so a system sets it from its clock rate and a bench can use small values. Command spacings, the strap hold time, the DLL lock interval and both register opcodes are parameters. Every pin is driven from a register.

Top module: `memInitSeq`

## Requirements
- R1: Reset and idle state. While `rstN` is low, and afterwards until `start` is seen: `memResetN`=0, `cke`=0, `csN`=`rasN`=`casN`=`weN`=1, `ba`=0, `addr`=0 and `initDone`=0.
- R2: `memResetN` rises W+1 clock edges after the edge that samples `start`. W is `waitCycles`, and a value of 0 counts as 1. Once high, `memResetN` stays high until reset.
- R3: `cke` follows the `termFull` strap from the cycle after `start` is sampled, and it is unchanged on the cycle `memResetN` rises. `cke` keeps the strap for STRAP_HOLD cycles after that rise, then goes high and stays high.
- R4: After the strap hold, the bus stays deselected (`csN`=1) for W more cycles. The first command then appears STRAP_HOLD+W cycles after `memResetN` rose. No command is issued while `memResetN` is low.
- R5: Exactly six commands are issued, in this order. Each is coded as {`rasN`,`casN`,`weN`} with `csN`=0.
  - Precharge-all: code 010, `addr` bit 8 set and all other address bits clear.
  - Extended register load: code 000, `ba`=001, `addr`=EMR_OPCODE.
  - Mode register load: code 000, `ba`=000, `addr`=MR_OPCODE with bit 8 (DLL reset) forced high.
  - Precharge-all: as above.
  - Auto refresh: code 001.
  - Auto refresh: code 001.
- R6: Each command lasts one cycle. Between commands the bus is deselected for T_RP cycles after a precharge, T_MRD cycles after a register load, and T_RFC cycles after a refresh.
- R7: `initDone` rises at the later of two points: T_RFC+1 cycles after the second refresh, or LOCK_CYCLES cycles after the mode register load.
- R8: Once high, `initDone` stays high until reset. `start` pulses during the sequence or after it change neither the timing nor any pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the power-up sequence (taken only when idle) |
| waitCycles | input | WAIT_W | Length of each long wait, in clocks |
| termFull | input | 1 | Strap level on CKE at reset release: 1 selects full termination, 0 selects half |
| memResetN | output | 1 | Device reset pin |
| cke | output | 1 | Clock enable and termination strap |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank / register select |
| addr | output | ADDR_W | Address / opcode bus |
| initDone | output | 1 | Sequence finished |

## Verification
A wrong internal state shows up as a command edge at the wrong cycle or with the wrong code. A corrupted wait or gap count moves every later command by the same amount, so the first command after the fault is already off. A skipped or repeated state changes the command count or order. A lock counter that starts late or expires early moves the `initDone` rise away from the mode-load plus LOCK_CYCLES point. A strap error shows as a `cke` change on the reset-release cycle.

// File: rtl/mem_init_pkg.sv
package mem_init_pkg;

  // Bit 8 carries both the all-bank flag and the DLL reset flag.
  localparam int AP_BIT      = 8;
  localparam int DLL_RST_BIT = 8;

  typedef enum logic [2:0] {
    CMD_DES, CMD_PREA, CMD_EMRS, CMD_MRS, CMD_REF
  } cmdKind_e;

  typedef enum logic [2:0] {
    DUR_WAIT, DUR_HOLD, DUR_RP, DUR_MRD, DUR_RFC, DUR_ONE
  } durSel_e;

  typedef struct packed {
    cmdKind_e cmd;
    logic     resHigh;
    logic     ckeStrap;
    logic     ckeHigh;
    logic     load;
    durSel_e  dur;
    logic     lockStart;
    logic     done;
  } seqStrobe_t;

  typedef struct packed {
    logic cntZero;
    logic lockDone;
  } seqStatus_t;

endpackage

// File: rtl/memInitCtrl.sv
module memInitCtrl
  import mem_init_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  seqStatus_t status,
  output seqStrobe_t strobe
);

  typedef enum logic [4:0] {
    S_IDLE, S_PRE_RES, S_HOLD, S_POST_RES,
    S_PREA1, S_GAP1, S_EMRS, S_GAP2, S_MRS, S_GAP3,
    S_PREA2, S_GAP4, S_REF1, S_GAP5, S_REF2, S_GAP6, S_DONE
  } seqState_e;

  seqState_e state, nxt;

  function automatic seqState_e succOf(input seqState_e s);
    case (s)
      S_PRE_RES:  return S_HOLD;
      S_HOLD:     return S_POST_RES;
      S_POST_RES: return S_PREA1;
      S_PREA1:    return S_GAP1;
      S_GAP1:     return S_EMRS;
      S_EMRS:     return S_GAP2;
      S_GAP2:     return S_MRS;
      S_MRS:      return S_GAP3;
      S_GAP3:     return S_PREA2;
      S_PREA2:    return S_GAP4;
      S_GAP4:     return S_REF1;
      S_REF1:     return S_GAP5;
      S_GAP5:     return S_REF2;
      S_REF2:     return S_GAP6;
      default:    return S_DONE;
    endcase
  endfunction

  function automatic durSel_e durOf(input seqState_e s);
    case (s)
      S_PRE_RES, S_POST_RES: return DUR_WAIT;
      S_HOLD:                return DUR_HOLD;
      S_GAP1, S_GAP4:        return DUR_RP;
      S_GAP2, S_GAP3:        return DUR_MRD;
      S_GAP5, S_GAP6:        return DUR_RFC;
      default:               return DUR_ONE;
    endcase
  endfunction

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:  if (start) nxt = S_PRE_RES;
      S_GAP6:  if (status.cntZero && status.lockDone) nxt = S_DONE;
      S_DONE:  nxt = S_DONE;
      default: if (status.cntZero) nxt = succOf(state);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    strobe.load      = (nxt != state);
    strobe.dur       = durOf(nxt);
    strobe.lockStart = (nxt == S_MRS) && (state != S_MRS);
    strobe.resHigh   = !(state inside {S_IDLE, S_PRE_RES});
    strobe.ckeStrap  = state inside {S_PRE_RES, S_HOLD};
    strobe.ckeHigh   = !(state inside {S_IDLE, S_PRE_RES, S_HOLD});
    strobe.done      = (state == S_DONE);
    case (state)
      S_PREA1, S_PREA2: strobe.cmd = CMD_PREA;
      S_EMRS:           strobe.cmd = CMD_EMRS;
      S_MRS:            strobe.cmd = CMD_MRS;
      S_REF1, S_REF2:   strobe.cmd = CMD_REF;
      default:          strobe.cmd = CMD_DES;
    endcase
  end

  // R8: the finished state is terminal, whatever start does
  assert_done_terminal_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DONE) |=> (state == S_DONE));

  // R2: leaving idle needs a start pulse
  assert_start_needed_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && !start) |=> (state == S_IDLE));

endmodule

// File: rtl/memInitDatapath.sv
module memInitDatapath
  import mem_init_pkg::*;
#(
  parameter int WAIT_W      = 16,
  parameter int ADDR_W      = 12,
  parameter int BA_W        = 3,
  parameter int STRAP_HOLD  = 4,
  parameter int T_RP        = 4,
  parameter int T_MRD       = 6,
  parameter int T_RFC       = 40,
  parameter int LOCK_CYCLES = 20000,
  parameter logic [ADDR_W-1:0] EMR_OPCODE = '0,
  parameter logic [ADDR_W-1:0] MR_OPCODE  = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WAIT_W-1:0] waitCycles,
  input  logic              termFull,
  input  seqStrobe_t        strobe,
  output seqStatus_t        status,
  output logic              memResetN,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              initDone
);

  localparam int CNT_W  = WAIT_W;
  localparam int LOCK_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [ADDR_W-1:0] AP_MASK  = ADDR_W'(1) << AP_BIT;
  localparam logic [ADDR_W-1:0] DLL_MASK = ADDR_W'(1) << DLL_RST_BIT;

  logic [CNT_W-1:0]  cnt, durVal, waitEff;
  logic [LOCK_W-1:0] lockCnt;
  logic              lockArmed;

  always_comb waitEff = (waitCycles == '0) ? CNT_W'(1) : waitCycles;

  always_comb begin
    case (strobe.dur)
      DUR_WAIT: durVal = waitEff;
      DUR_HOLD: durVal = CNT_W'(STRAP_HOLD);
      DUR_RP:   durVal = CNT_W'(T_RP);
      DUR_MRD:  durVal = CNT_W'(T_MRD);
      DUR_RFC:  durVal = CNT_W'(T_RFC);
      default:  durVal = CNT_W'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cnt <= '0;
    else if (strobe.load)     cnt <= durVal - 1'b1;
    else if (cnt != '0)       cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockCnt   <= '0;
      lockArmed <= 1'b0;
    end else if (strobe.lockStart) begin
      lockCnt   <= LOCK_W'(LOCK_CYCLES - 1);
      lockArmed <= 1'b1;
    end else if (lockArmed && lockCnt != '0) begin
      lockCnt   <= lockCnt - 1'b1;
    end
  end

  always_comb begin
    status.cntZero  = (cnt == '0);
    status.lockDone = lockArmed && (lockCnt == '0);
  end

  logic [3:0]        cmdBits;
  logic [BA_W-1:0]   baNext;
  logic [ADDR_W-1:0] addrNext;

  always_comb begin
    cmdBits  = 4'b1111;
    baNext   = '0;
    addrNext = '0;
    case (strobe.cmd)
      CMD_PREA: begin cmdBits = 4'b0010; addrNext = AP_MASK; end
      CMD_EMRS: begin cmdBits = 4'b0000; baNext = BA_W'(1); addrNext = EMR_OPCODE; end
      CMD_MRS:  begin cmdBits = 4'b0000; addrNext = MR_OPCODE | DLL_MASK; end
      CMD_REF:  begin cmdBits = 4'b0001; end
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memResetN <= 1'b0;
      cke       <= 1'b0;
      {csN, rasN, casN, weN} <= 4'b1111;
      ba        <= '0;
      addr      <= '0;
      initDone  <= 1'b0;
    end else begin
      memResetN <= strobe.resHigh;
      cke       <= strobe.ckeHigh | (strobe.ckeStrap & termFull);
      {csN, rasN, casN, weN} <= cmdBits;
      ba        <= baNext;
      addr      <= addrNext;
      if (strobe.done) initDone <= 1'b1;
    end
  end

  assert_cmd_one_cycle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !csN |=> csN);

  assert_reset_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    memResetN |=> memResetN);

  assert_strap_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memResetN) |-> $stable(cke));

  assert_quiet_in_reset_R4: assert property (@(posedge clk) disable iff (!rstN)
    !memResetN |-> csN);

  assert_mrs_dll_bit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !rasN && !casN && !weN && ba == '0) |-> addr[DLL_RST_BIT]);

  assert_done_after_lock_R7: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> status.lockDone);

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

endmodule

// File: rtl/memInitSeq.sv
module memInitSeq
  import mem_init_pkg::*;
#(
  parameter int WAIT_W      = 16,
  parameter int ADDR_W      = 12,
  parameter int BA_W        = 3,
  parameter int STRAP_HOLD  = 4,
  parameter int T_RP        = 4,
  parameter int T_MRD       = 6,
  parameter int T_RFC       = 40,
  parameter int LOCK_CYCLES = 20000,
  parameter logic [ADDR_W-1:0] EMR_OPCODE = '0,
  parameter logic [ADDR_W-1:0] MR_OPCODE  = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [WAIT_W-1:0] waitCycles,
  input  logic              termFull,
  output logic              memResetN,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              initDone
);

  seqStrobe_t strobe;
  seqStatus_t status;

  memInitCtrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .status (status),
    .strobe (strobe)
  );

  memInitDatapath #(
    .WAIT_W      (WAIT_W),
    .ADDR_W      (ADDR_W),
    .BA_W        (BA_W),
    .STRAP_HOLD  (STRAP_HOLD),
    .T_RP        (T_RP),
    .T_MRD       (T_MRD),
    .T_RFC       (T_RFC),
    .LOCK_CYCLES (LOCK_CYCLES),
    .EMR_OPCODE  (EMR_OPCODE),
    .MR_OPCODE   (MR_OPCODE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .waitCycles (waitCycles),
    .termFull   (termFull),
    .strobe     (strobe),
    .status     (status),
    .memResetN  (memResetN),
    .cke        (cke),
    .csN        (csN),
    .rasN       (rasN),
    .casN       (casN),
    .weN        (weN),
    .ba         (ba),
    .addr       (addr),
    .initDone   (initDone)
  );

endmodule

// File: tb/memInitSeq_tb.sv
module memInitSeq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WAIT_W = 16;
  localparam int H      = 3;
  localparam int TRP    = 2;
  localparam int TMRD   = 4;
  localparam int TRFC   = 5;
  localparam int LOCK   = 24;
  localparam logic [11:0] EMR = 12'h044;
  localparam logic [11:0] MR  = 12'h053;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [WAIT_W-1:0] waitCycles = '0;
  logic termFull = 1'b0;
  logic memResetN, cke, csN, rasN, casN, weN, initDone;
  logic [2:0]  ba;
  logic [11:0] addr;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  memInitSeq #(
    .WAIT_W(WAIT_W), .ADDR_W(12), .BA_W(3), .STRAP_HOLD(H),
    .T_RP(TRP), .T_MRD(TMRD), .T_RFC(TRFC), .LOCK_CYCLES(LOCK),
    .EMR_OPCODE(EMR), .MR_OPCODE(MR)
  ) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .waitCycles(waitCycles),
    .termFull(termFull), .memResetN(memResetN), .cke(cke), .csN(csN),
    .rasN(rasN), .casN(casN), .weN(weN), .ba(ba), .addr(addr),
    .initDone(initDone)
  );

  task automatic chkEq(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int expDone(input int mrsCyc, input int ref2Cyc);
    int a = ref2Cyc + 1 + TRFC;
    int b = mrsCyc + LOCK;
    return (a > b) ? a : b;
  endfunction

  task automatic runSeq(input int w, input bit strap, input int midStart);
    int we, startCyc, resRise, ckeRise, nCmd, doneCyc;
    bit ckeDrop;
    int cmdCyc[6];
    int cmdCode[6];
    int cmdBa[6];
    int cmdAddr[6];
    int expC[6];
    int expCode[6];
    int expBa[6];
    int expAddr[6];
    int gapAfter[6];

    we = (w == 0) ? 1 : w;
    rstN = 1'b0; start = 1'b0; waitCycles = WAIT_W'(w); termFull = strap;
    repeat (3) @(negedge clk);
    // R1: reset state
    chkEq("R1", "memResetN in reset", memResetN, 0);
    chkEq("R1", "cke in reset", cke, 0);
    chkEq("R1", "bus in reset", {csN, rasN, casN, weN}, 4'b1111);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chkEq("R1", "idle pins", {memResetN, cke, csN, rasN, casN, weN, initDone}, 7'b0011110);
    chkEq("R1", "idle addr/ba", {ba, addr}, 0);

    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    startCyc = cyc;
    resRise = -1; ckeRise = -1; nCmd = 0; doneCyc = -1; ckeDrop = 1'b0;
    for (int k = 0; k < 3000 && doneCyc < 0; k++) begin
      start = (k == midStart);
      if (memResetN && resRise < 0) begin
        resRise = cyc;
        chkEq("R3", "cke at reset release", cke, strap);
      end
      if (cke && ckeRise < 0) ckeRise = cyc;
      if (!cke && ckeRise >= 0) ckeDrop = 1'b1;
      if (!csN) begin
        if (nCmd < 6) begin
          cmdCyc[nCmd]  = cyc;
          cmdCode[nCmd] = {rasN, casN, weN};
          cmdBa[nCmd]   = ba;
          cmdAddr[nCmd] = addr;
        end
        nCmd++;
      end
      if (initDone) doneCyc = cyc;
      @(negedge clk);
    end
    start = 1'b0;

    chkEq("R2", "reset release cycle", resRise, startCyc + we + 1);
    chkEq("R3", "cke first high", ckeRise, strap ? startCyc + 1 : resRise + H);
    chkEq("R3", "cke dropped after high", ckeDrop, 0);
    chkEq("R5", "command count", nCmd, 6);

    expCode = '{3'b010, 3'b000, 3'b000, 3'b010, 3'b001, 3'b001};
    expBa   = '{0, 1, 0, 0, 0, 0};
    expAddr = '{12'h100, EMR, MR | 12'h100, 12'h100, 0, 0};
    gapAfter = '{TRP, TMRD, TMRD, TRP, TRFC, TRFC};
    expC[0] = resRise + H + we;              // R4
    for (int i = 1; i < 6; i++) expC[i] = expC[i-1] + 1 + gapAfter[i-1];

    if (nCmd == 6) begin
      chkEq("R4", "first command cycle", cmdCyc[0], expC[0]);
      for (int i = 0; i < 6; i++) begin
        chkEq("R5", $sformatf("cmd%0d code", i), cmdCode[i], expCode[i]);
        chkEq("R5", $sformatf("cmd%0d ba", i), cmdBa[i], expBa[i]);
        if (i < 4) chkEq("R5", $sformatf("cmd%0d addr", i), cmdAddr[i], expAddr[i]);
        if (i > 0) chkEq("R6", $sformatf("cmd%0d cycle", i), cmdCyc[i], expC[i]);
      end
      chkEq("R7", "done cycle", doneCyc, expDone(cmdCyc[2], cmdCyc[5]));
      if (midStart > 0) chkEq("R8", "mid-sequence start ignored", doneCyc, expDone(expC[2], expC[5]));
    end

    // R8: start after completion has no effect
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (!csN || !initDone || !memResetN || !cke) begin
        chkEq("R8", "pins after late start", {memResetN, cke, csN, initDone}, 4'b1111);
        break;
      end
    end
    chkEq("R8", "done held", {memResetN, cke, csN, initDone}, 4'b1111);
  endtask

  initial begin
    void'($urandom(32'd2024));
    runSeq(0, 1'b0, -1);        // zero wait clamps to one
    runSeq(1, 1'b1, -1);
    runSeq(7, 1'b0, 5);         // start pulse mid-sequence
    for (int r = 0; r < 6; r++) begin
      runSeq(int'($urandom_range(1, 40)), bit'($urandom_range(0, 1)),
             int'($urandom_range(1, 60)));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule